// File: doc/BRIEF.md
# Tree Partial-Sum Reduction Engine

This block folds a bank of partial sums into one total by a halving tree of pairwise integer additions. A single start pulse captures all N partial sums at once from a flat input bus, with lane i taken from bits `i*W +: W`. The engine then runs one reduction round per clock. Every round is a barrier step: all of its additions commit on the same edge, and the next round only ever sees their results.

In each round the live count is halved with integer division. Every lane below the new count adds in the lane that sits the new count above it. When the live count is odd, the surplus top element is folded into lane 0 in the same round. Because of this, the input count does not have to be a power of two. When one value remains, the block raises a one-cycle completion pulse, and the total stays on the output until the next accepted start. A step strobe, a round number and the live count are presented after every round.

Top module: `rdx_tree_top`

## Requirements
- R1: While reset is high, and on the cycle after it, `busy`, `done` and `step_pulse` are 0, and `step_num`, `live_cnt` and `total` are 0. A reset in the middle of a reduction abandons it, and no `done` follows.
- R2: A `start` seen while idle captures all N lanes from `parts_in` (lane i at bits i*W +: W) on that edge. On the next cycle `busy` is 1, `live_cnt` is N and `total` shows lane 0.
- R3: In a round that begins with an odd live count c, lane 0 also absorbs the lane at index c-1, in addition to its pairwise partner.
- R4: Each round sets the live count to floor(c/2) and replaces every lane i below that value by lane i plus lane i+floor(c/2). After each round `step_pulse` is 1 for one cycle, `live_cnt` shows the new count and `step_num` shows the number of rounds completed.
- R5: Exactly one round completes per clock. `done` appears L cycles after the capture edge, where L is the number of halvings that take N down to 1, and L is 1 when N is 1.
- R6: `done` is a single-cycle pulse. `busy` falls in that same cycle, and `total` then equals the sum of all N captured values.
- R7: While idle and without `start`, `total` holds its value from cycle to cycle.
- R8: A `start` that arrives while `busy` is 1 is ignored. The running reduction continues and keeps its round number and result.
- R9: Additions wrap modulo 2^W, and no overflow indication is produced.
- R10: With N = 1 the block completes one cycle after capture, and `total` equals the single input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Capture the inputs and begin a reduction (idle only) |
| parts_in | input | N_PARTS*W | Flat bus of partial sums, lane i at bits i*W +: W |
| busy | output | 1 | Reduction in progress |
| done | output | 1 | One-cycle completion pulse |
| total | output | W | Lane 0; the full sum once done has pulsed |
| step_pulse | output | 1 | High for one cycle after each round |
| step_num | output | $clog2(rounds+1), min 1 | Rounds completed in the current or last reduction |
| live_cnt | output | $clog2(N_PARTS+1) | Live element count after the latest round |

## Verification
The embedded properties assume that `parts_in` is meaningful only on the edge where an idle engine accepts `start`. They also assume that `start` may arrive at any time, including during a run, and that reset may cut a run short. The stimulus drives `start` and the data bus only between clock edges. It changes the data bus only while idle, apart from one deliberate case where the bus changes and `start` is pulsed in the middle of a run to show that neither is taken. Five more engine sizes run alongside the default one, so that odd counts, a power of two and the single-element case all execute under the same start pulses.

// File: rtl/rdx_pkg.sv
package rdx_pkg;

    typedef enum logic [0:0] {
        RDX_IDLE = 1'b0,
        RDX_RUN  = 1'b1
    } rdx_state_e;

    typedef struct packed {
        logic load;
        logic advance;
        logic finish;
    } rdx_ctl_t;

    // number of halvings that bring n down to one
    function automatic int rdx_round_total(input int n);
        int c;
        int r;
        c = n;
        r = 0;
        while (c > 1) begin
            c = c / 2;
            r = r + 1;
        end
        return r;
    endfunction

    function automatic int rdx_cnt_bits(input int n);
        return $clog2(n + 1);
    endfunction

    function automatic int rdx_step_bits(input int n);
        int b;
        b = $clog2(rdx_round_total(n) + 1);
        return (b < 1) ? 1 : b;
    endfunction

endpackage

// File: rtl/rdx_lane.sv
module rdx_lane #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         pair_en,
    input  logic         fold_en,
    input  logic [W-1:0] ld_val,
    input  logic [W-1:0] partner,
    input  logic [W-1:0] tail,
    output logic [W-1:0] val_q
);

    logic [W-1:0] addend_a;
    logic [W-1:0] addend_b;
    logic [W-1:0] sum_nx;

    always_comb begin
        addend_a = pair_en ? partner : '0;
        addend_b = fold_en ? tail : '0;
        sum_nx   = val_q + addend_a + addend_b;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            val_q <= '0;
        end else if (load) begin
            val_q <= ld_val;
        end else if (pair_en || fold_en) begin
            val_q <= sum_nx;
        end
    end

endmodule

// File: rtl/rdx_ctrl.sv
module rdx_ctrl
    import rdx_pkg::*;
#(
    parameter int N_PARTS = 100,
    parameter int CW      = 7,
    parameter int RW      = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    output rdx_ctl_t      ctl,
    output logic [CW-1:0] live_cnt,
    output logic          busy,
    output logic          done,
    output logic          step_pulse,
    output logic [RW-1:0] step_num
);

    localparam logic [CW-1:0] FULL_CNT = CW'(N_PARTS);
    localparam logic [CW-1:0] ONE_CNT  = CW'(1);

    rdx_state_e    state_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_nx;
    logic [RW-1:0] round_q;
    logic          done_q;
    logic          step_q;

    always_comb begin
        cnt_nx      = cnt_q >> 1;
        ctl.load    = (state_q == RDX_IDLE) && start;
        ctl.advance = (state_q == RDX_RUN) && (cnt_q > ONE_CNT);
        ctl.finish  = (state_q == RDX_RUN) &&
                      ((cnt_q <= ONE_CNT) || (cnt_nx == ONE_CNT));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RDX_IDLE;
            cnt_q   <= '0;
            round_q <= '0;
            done_q  <= 1'b0;
            step_q  <= 1'b0;
        end else begin
            done_q <= ctl.finish;
            step_q <= ctl.advance;
            if (ctl.load) begin
                state_q <= RDX_RUN;
                cnt_q   <= FULL_CNT;
                round_q <= '0;
            end else begin
                if (ctl.advance) begin
                    cnt_q   <= cnt_nx;
                    round_q <= round_q + RW'(1);
                end
                if (ctl.finish) begin
                    state_q <= RDX_IDLE;
                end
            end
        end
    end

    assign live_cnt   = cnt_q;
    assign busy       = (state_q == RDX_RUN);
    assign done       = done_q;
    assign step_pulse = step_q;
    assign step_num   = round_q;

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!busy && !done && !step_pulse && (step_num == '0)));

    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6
    done_at_one_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> ((live_cnt == ONE_CNT) && !busy));

    // R4
    count_halves_chk: assert property (@(posedge clk) disable iff (rst)
        step_pulse |-> (live_cnt == ($past(live_cnt) >> 1)));

    // R8
    start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && start && ctl.advance) |=> (step_num == $past(step_num) + RW'(1)));

endmodule

// File: rtl/rdx_bank.sv
module rdx_bank
    import rdx_pkg::*;
#(
    parameter int N_PARTS = 100,
    parameter int W       = 32,
    parameter int CW      = 7
) (
    input  logic                 clk,
    input  logic                 rst,
    input  rdx_ctl_t             ctl,
    input  logic [CW-1:0]        cnt,
    input  logic [N_PARTS*W-1:0] parts_in,
    output logic [W-1:0]         elem0
);

    localparam int PIW      = (N_PARTS > 1) ? $clog2(N_PARTS) : 1;
    localparam int PAIR_MAX = N_PARTS / 2;

    logic [N_PARTS-1:0][W-1:0] elem_q;
    logic [CW-1:0]             half;
    logic                      odd;
    logic [W-1:0]              tail;

    always_comb begin
        half = cnt >> 1;
        odd  = cnt[0];
    end

    if (N_PARTS > 1) begin : g_tail
        logic [PIW-1:0] tidx;
        always_comb begin
            tidx = PIW'(cnt - CW'(1));
            tail = elem_q[tidx];
        end
    end else begin : g_no_tail
        assign tail = '0;
    end

    for (genvar i = 0; i < N_PARTS; i++) begin : g_lane
        logic         pair_en;
        logic         fold_en;
        logic [W-1:0] partner;

        if (i < PAIR_MAX) begin : g_pair
            logic [PIW-1:0] pidx;
            always_comb begin
                pidx    = PIW'(CW'(i) + half);
                pair_en = ctl.advance && (CW'(i) < half);
                partner = pair_en ? elem_q[pidx] : '0;
            end
        end else begin : g_nopair
            assign pair_en = 1'b0;
            assign partner = '0;
        end

        if (i == 0) begin : g_fold
            assign fold_en = ctl.advance && odd;
        end else begin : g_nofold
            assign fold_en = 1'b0;
        end

        rdx_lane #(.W(W)) u_lane (
            .clk     (clk),
            .rst     (rst),
            .load    (ctl.load),
            .pair_en (pair_en),
            .fold_en (fold_en),
            .ld_val  (parts_in[i*W +: W]),
            .partner (partner),
            .tail    ((i == 0) ? tail : '0),
            .val_q   (elem_q[i])
        );
    end

    assign elem0 = elem_q[0];

    // R2
    load_first_chk: assert property (@(posedge clk) disable iff (rst)
        ctl.load |=> (elem_q[0] == $past(parts_in[W-1:0])));

    // R2
    load_last_chk: assert property (@(posedge clk) disable iff (rst)
        ctl.load |=> (elem_q[N_PARTS-1] == $past(parts_in[N_PARTS*W-1 -: W])));

endmodule

// File: rtl/rdx_tree_top.sv
module rdx_tree_top
    import rdx_pkg::*;
#(
    parameter int N_PARTS = 100,
    parameter int W       = 32
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic                                   start,
    input  logic [N_PARTS*W-1:0]                   parts_in,
    output logic                                   busy,
    output logic                                   done,
    output logic [W-1:0]                           total,
    output logic                                   step_pulse,
    output logic [rdx_step_bits(N_PARTS)-1:0]      step_num,
    output logic [rdx_cnt_bits(N_PARTS)-1:0]       live_cnt
);

    localparam int CW = rdx_cnt_bits(N_PARTS);
    localparam int RW = rdx_step_bits(N_PARTS);

    rdx_ctl_t      ctl;
    logic [CW-1:0] cnt_w;

    rdx_ctrl #(
        .N_PARTS (N_PARTS),
        .CW      (CW),
        .RW      (RW)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .ctl        (ctl),
        .live_cnt   (cnt_w),
        .busy       (busy),
        .done       (done),
        .step_pulse (step_pulse),
        .step_num   (step_num)
    );

    rdx_bank #(
        .N_PARTS (N_PARTS),
        .W       (W),
        .CW      (CW)
    ) u_bank (
        .clk      (clk),
        .rst      (rst),
        .ctl      (ctl),
        .cnt      (cnt_w),
        .parts_in (parts_in),
        .elem0    (total)
    );

    assign live_cnt = cnt_w;

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(total));

endmodule

// File: tb/rdx_tree_top_tb_top.sv
module rdx_tree_top_tb_top;
    import rdx_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 32;
    localparam int N_MAIN     = 100;
    localparam int CW_M       = rdx_cnt_bits(N_MAIN);
    localparam int RW_M       = rdx_step_bits(N_MAIN);
    localparam int N_VEC      = 6;
    localparam int N_SIZES    = 5;

    typedef struct packed {
        logic [31:0] seed;
        logic [31:0] step;
    } vec_t;

    localparam vec_t VECS [N_VEC] = '{
        '{32'd1,          32'd1},
        '{32'd0,          32'd0},
        '{32'hFFFF_FFFF,  32'd0},
        '{32'h8000_0000,  32'h1234_5677},
        '{32'd5,          32'hDEAD_BEEF},
        '{32'h7FFF_FFFF,  32'd1}
    };

    localparam int SIZES [N_SIZES] = '{1, 2, 3, 7, 64};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] cur_seed = '0;
    logic [31:0] cur_step = '0;
    int          cyc = 0;
    int          launch_cyc = 0;
    logic        chk_on = 1'b0;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] pat(input logic [31:0] s, input logic [31:0] st, input int i);
        return s + st * 32'(i);
    endfunction

    function automatic logic [31:0] ref_sum(input logic [31:0] s, input logic [31:0] st, input int n);
        logic [31:0] acc;
        acc = '0;
        for (int i = 0; i < n; i++) acc = acc + pat(s, st, i);
        return acc;
    endfunction

    function automatic int ref_lat(input int n);
        int c;
        int r;
        c = n;
        r = 0;
        while (c > 1) begin
            c = c / 2;
            r = r + 1;
        end
        return (r < 1) ? 1 : r;
    endfunction

    function automatic int ref_cnt_after(input int n, input int r);
        int c;
        c = n;
        for (int k = 0; k < r; k++) c = c / 2;
        return c;
    endfunction

    // main instance, default size
    logic [N_MAIN*W-1:0] vec_m;
    logic                busy_m, done_m, sp_m;
    logic [W-1:0]        tot_m;
    logic [RW_M-1:0]     sn_m;
    logic [CW_M-1:0]     lc_m;

    always_comb begin
        for (int i = 0; i < N_MAIN; i++) vec_m[i*W +: W] = pat(cur_seed, cur_step, i);
    end

    rdx_tree_top #(.N_PARTS(N_MAIN), .W(W)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .parts_in   (vec_m),
        .busy       (busy_m),
        .done       (done_m),
        .total      (tot_m),
        .step_pulse (sp_m),
        .step_num   (sn_m),
        .live_cnt   (lc_m)
    );

    // further sizes run alongside; each checks its own completion cycle and sum
    for (genvar k = 0; k < N_SIZES; k++) begin : g_sz
        localparam int NK  = SIZES[k];
        localparam int CWK = rdx_cnt_bits(NK);
        localparam int RWK = rdx_step_bits(NK);

        logic [NK*W-1:0] vec;
        logic            bz, dn, sp;
        logic [W-1:0]    tot;
        logic [RWK-1:0]  sn;
        logic [CWK-1:0]  lc;
        int              k_chk = 0;
        int              k_fail = 0;

        always_comb begin
            for (int i = 0; i < NK; i++) vec[i*W +: W] = pat(cur_seed, cur_step, i);
        end

        rdx_tree_top #(.N_PARTS(NK), .W(W)) u_dut (
            .clk        (clk),
            .rst        (rst),
            .start      (start),
            .parts_in   (vec),
            .busy       (bz),
            .done       (dn),
            .total      (tot),
            .step_pulse (sp),
            .step_num   (sn),
            .live_cnt   (lc)
        );

        // R3 (odd sizes 3, 7), R5, R6, R10 (size 1)
        always @(negedge clk) begin
            if (chk_on) begin
                if (cyc == launch_cyc + ref_lat(NK)) begin
                    k_chk = k_chk + 1;
                    if (!(dn && !bz && tot == ref_sum(cur_seed, cur_step, NK))) begin
                        k_fail = k_fail + 1;
                        $display("FAIL R3/R5/R6/R10 N=%0d done=%0b actual=%0h expected=%0h",
                                 NK, dn, tot, ref_sum(cur_seed, cur_step, NK));
                    end
                end else if (dn) begin
                    k_chk = k_chk + 1;
                    k_fail = k_fail + 1;
                    $display("FAIL R5 N=%0d done at cycle actual=%0d expected=%0d",
                             NK, cyc - launch_cyc, ref_lat(NK));
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        int t_all;
        int f_all;
        t_all = n_chk + g_sz[0].k_chk + g_sz[1].k_chk + g_sz[2].k_chk + g_sz[3].k_chk + g_sz[4].k_chk;
        f_all = n_fail + g_sz[0].k_fail + g_sz[1].k_fail + g_sz[2].k_fail + g_sz[3].k_fail + g_sz[4].k_fail;
        $display("%0d/%0d checks passed", t_all - f_all, t_all);
    endtask

    task automatic launch();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        launch_cyc = cyc;
    endtask

    // full run on the main instance with per-round checks
    task automatic run_main();
        logic [31:0] exp_sum;
        int          lat;
        exp_sum = ref_sum(cur_seed, cur_step, N_MAIN);
        lat = ref_lat(N_MAIN);
        launch();
        // R2
        chk(busy_m && lc_m == CW_M'(N_MAIN) && tot_m == pat(cur_seed, cur_step, 0),
            "R2 capture", {32'(lc_m), tot_m}, {32'(N_MAIN), pat(cur_seed, cur_step, 0)});
        for (int r = 1; r <= lat; r++) begin
            @(negedge clk);
            // R4
            chk(lc_m == CW_M'(ref_cnt_after(N_MAIN, r)) && sp_m && sn_m == RW_M'(r),
                "R4 round step", {31'(lc_m), sp_m, 32'(sn_m)},
                {31'(ref_cnt_after(N_MAIN, r)), 1'b1, 32'(r)});
            if (r < lat) begin
                // R5
                chk(busy_m && !done_m, "R5 still running", {busy_m, done_m}, 64'h2);
            end else begin
                // R6 / R3 / R9
                chk(done_m && !busy_m && tot_m == exp_sum, "R6 R3 R9 total",
                    {31'(done_m), busy_m, tot_m}, {31'd1, 1'b0, exp_sum});
            end
        end
        @(negedge clk);
        // R6
        chk(!done_m && !sp_m, "R6 single pulse", {done_m, sp_m}, 64'h0);
    endtask

    initial begin
        logic [31:0] saved;
        logic [31:0] seed_a;
        bit          saw_done;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        // R1
        chk(!busy_m && !done_m && !sp_m && sn_m == '0 && lc_m == '0 && tot_m == '0,
            "R1 reset state", {busy_m, done_m, sp_m, 32'(sn_m)}, 64'h0);
        rst = 1'b0;
        @(negedge clk);

        for (int v = 0; v < N_VEC; v++) begin
            cur_seed = VECS[v].seed;
            cur_step = VECS[v].step;
            chk_on = 1'b1;
            run_main();
            repeat (4) @(negedge clk);
        end
        chk_on = 1'b0;

        // R9: all lanes at the largest value wrap to -N
        cur_seed = 32'hFFFF_FFFF;
        cur_step = 32'd0;
        run_main();
        chk(tot_m == 32'hFFFF_FF9C, "R9 wrap", tot_m, 32'hFFFF_FF9C);

        // R7: result held while idle
        saved = tot_m;
        repeat (5) @(negedge clk);
        chk(tot_m == saved && !busy_m && !done_m, "R7 hold", tot_m, saved);

        // R8: start and new data during a run are ignored
        cur_seed = 32'h0000_1000;
        cur_step = 32'd3;
        seed_a = cur_seed;
        launch();
        repeat (2) @(negedge clk);
        cur_seed = 32'h5555_0000;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(sn_m == RW_M'(3) && lc_m == CW_M'(12) && busy_m, "R8 run continues",
            {32'(sn_m), 32'(lc_m)}, {32'd3, 32'd12});
        repeat (3) @(negedge clk);
        chk(done_m && tot_m == ref_sum(seed_a, 32'd3, N_MAIN), "R8 original total",
            tot_m, ref_sum(seed_a, 32'd3, N_MAIN));
        repeat (3) @(negedge clk);

        // R1: reset during a run abandons it
        launch();
        repeat (2) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(!busy_m && !done_m && sn_m == '0 && lc_m == '0, "R1 mid-run reset",
            {busy_m, done_m, 32'(sn_m)}, 64'h0);
        rst = 1'b0;
        saw_done = 1'b0;
        for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            if (done_m || busy_m) saw_done = 1'b1;
        end
        chk(!saw_done, "R1 no completion after reset", 64'(saw_done), 64'h0);

        finished = 1'b1;
        report();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk = n_chk + 1;
            n_fail = n_fail + 1;
            $display("FAIL watchdog run did not finish actual=%0d expected=%0d", cyc, 0);
            report();
            $finish;
        end
    end

endmodule